// File: doc/BRIEF.md
# Legacy PC I/O Interrupt and Port Register Front End

This block answers byte-wide register accesses that land in a 256-byte legacy I/O window. Addresses arrive as offsets from the window base. Its main content is a reduced primary interrupt controller. That controller holds an 8-bit pending byte and an 8-bit enable set, and it drives one level-sensitive interrupt line. Software writes an active-low mask, which the block stores inverted as the enable set. Software clears pending bits by writing a bit index to the acknowledge port. Hardware sources set and clear pending bits directly through two vector inputs.

Around the controller the block offers four further services. An index and data port pair forwards accesses to an external real-time clock. A system control port reports the output of an external timer channel. Two DMA mode bytes are kept and exposed. Writes to a set of DMA, keyboard and secondary-acknowledge ports are accepted and discarded. The secondary controller is a stub: its status reads zero and its mask is stored but raises nothing. Each request gets a response one cycle later, carrying read data and an error flag.

Top module: `legacy_io_regs`

## Requirements
- R1: After reset the pending byte and the enable set are zero. A read of the primary mask (offset 0x21) therefore returns 0xFF. `irq`, `rsp_valid`, `rsp_err`, `rtc_idx` and both DMA mode outputs are zero.
- R2: A byte write to the primary mask (0x21) stores the complement of the data as the enable set. A following read of 0x21 returns the byte that was written.
- R3: `irq` is high exactly when the pending byte ANDed with the enable set is nonzero. It follows any change to pending or enable one clock later, including a mask write alone.
- R4: A byte write to offset 0x20 is an acknowledge. Bits 3:0 of the data give an index. Indices 0–7 clear that pending bit. Indices 8–15 leave the pending byte unchanged.
- R5: Each set bit of `hw_post` sets the matching pending bit. Each set bit of `hw_clear` clears it. When a post falls in the same cycle as a clear or an acknowledge of the same bit, the post wins.
- R6: A byte read of 0x20 returns the pending byte. A 64-bit read (`bus_wide`=1) of 0x20 returns the pending byte zero-extended. A read of 0xA0 always returns zero.
- R7: A write to the secondary mask (0xA1) is stored and reads back as written. It never changes `irq`.
- R8: A write to 0x70 latches `rtc_idx`. A byte write to 0x71 raises `rtc_wr` in the request cycle, with `rtc_wdata` equal to the data. A byte read of 0x71 raises `rtc_rd` and returns `rtc_rdata` as sampled in the request cycle.
- R9: A byte read of 0x61 returns 0x20 when `timer2_out` is high and 0x00 when it is low. Writes to 0x61 are accepted without error.
- R10: Writes to 0x0B and 0xD6 are kept on `dma_mode0` and `dma_mode1`. Writes to 0x08, 0x0A, 0x0D, 0x0F, 0xD0, 0xD4, 0xDA, 0xDE, 0x64 and 0xA0 complete without error and change no state.
- R11: Each of the following returns zero data with `rsp_err` high for one cycle and changes no register: an undecoded offset, a read of a write-only port, or a 64-bit access other than a read of 0x20.
- R12: Every request cycle produces `rsp_valid` high on the next cycle. It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = byte access |
| bus_addr | input | 8 | Offset inside the window |
| bus_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 64 | Read data, zero on writes and errors |
| rsp_err | output | 1 | Access was rejected |
| hw_post | input | 8 | Hardware pending-set vector |
| hw_clear | input | 8 | Hardware pending-clear vector |
| irq | output | 1 | Level interrupt output |
| rtc_idx | output | 8 | Latched clock register index |
| rtc_wdata | output | 8 | Data for clock writes |
| rtc_wr | output | 1 | Clock write strobe |
| rtc_rd | output | 1 | Clock read strobe |
| rtc_rdata | input | 8 | Data returned by the clock |
| timer2_out | input | 1 | Output of external timer channel 2 |
| dma_mode0 | output | 8 | Retained first DMA mode byte |
| dma_mode1 | output | 8 | Retained second DMA mode byte |

## Verification
The interrupt path is exercised with several stimulus patterns, each separating a different fault:
- Mask writes alone, on a fixed pending byte. These show whether the line is re-evaluated on an enable change or only on a pending change.
- Acknowledge indices above 7 next to valid ones. These catch an index that is not bounded or is truncated.
- A post landing together with a clear, and with an acknowledge of the same bit. These fix the priority order.
- Byte and 64-bit reads of the status port. These separate the one legal wide access from the rejected ones.

Undecoded, write-only and wrong-size accesses are interleaved with state-holding writes. This shows that a rejected access leaves every retained byte unchanged.

// File: rtl/legacy_io_pkg.sv
package legacy_io_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_P1_MASK,
        SEL_P2_MASK,
        SEL_P1_STAT,
        SEL_P2_STAT,
        SEL_RTC_IDX,
        SEL_RTC_DATA,
        SEL_PORTB,
        SEL_DMA_MODE0,
        SEL_DMA_MODE1,
        SEL_SINK
    } io_sel_e;

endpackage

// File: rtl/legacy_io_decode.sv
module legacy_io_decode
    import legacy_io_pkg::*;
#(
    parameter int AW = 8,
    parameter logic [AW-1:0] OFS_P1_STAT  = 8'h20,
    parameter logic [AW-1:0] OFS_P1_MASK  = 8'h21,
    parameter logic [AW-1:0] OFS_P2_STAT  = 8'hA0,
    parameter logic [AW-1:0] OFS_P2_MASK  = 8'hA1,
    parameter logic [AW-1:0] OFS_RTC_IDX  = 8'h70,
    parameter logic [AW-1:0] OFS_RTC_DATA = 8'h71,
    parameter logic [AW-1:0] OFS_PORTB    = 8'h61,
    parameter logic [AW-1:0] OFS_DMA_MODE0 = 8'h0B,
    parameter logic [AW-1:0] OFS_DMA_MODE1 = 8'hD6,
    parameter int NSINK = 9,
    parameter logic [NSINK*AW-1:0] SINK_OFS =
        {8'h64, 8'hDE, 8'hDA, 8'hD4, 8'hD0, 8'h0F, 8'h0D, 8'h0A, 8'h08}
) (
    input  logic          wr,
    input  logic          wide,
    input  logic [AW-1:0] offset,
    output io_sel_e       sel,
    output logic          bad
);

    logic [NSINK-1:0] sink_hit;

    for (genvar g = 0; g < NSINK; g++) begin : g_sink
        assign sink_hit[g] = (offset == SINK_OFS[g*AW +: AW]);
    end

    always_comb begin
        sel = SEL_NONE;
        if (wide) begin
            if (!wr && offset == OFS_P1_STAT) sel = SEL_P1_STAT;
        end else if (offset == OFS_P1_MASK) begin
            sel = SEL_P1_MASK;
        end else if (offset == OFS_P2_MASK) begin
            sel = SEL_P2_MASK;
        end else if (offset == OFS_P1_STAT) begin
            sel = SEL_P1_STAT;
        end else if (offset == OFS_P2_STAT) begin
            sel = SEL_P2_STAT;
        end else if (offset == OFS_RTC_DATA) begin
            sel = SEL_RTC_DATA;
        end else if (offset == OFS_PORTB) begin
            sel = SEL_PORTB;
        end else if (wr) begin
            if (offset == OFS_RTC_IDX)        sel = SEL_RTC_IDX;
            else if (offset == OFS_DMA_MODE0) sel = SEL_DMA_MODE0;
            else if (offset == OFS_DMA_MODE1) sel = SEL_DMA_MODE1;
            else if (|sink_hit)               sel = SEL_SINK;
        end
        bad = (sel == SEL_NONE);
    end

endmodule

// File: rtl/legacy_irq_core.sv
module legacy_irq_core #(
    parameter int W  = 8,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mask_wr,
    input  logic [W-1:0]  mask_wdata,
    input  logic          ack_wr,
    input  logic [IW-1:0] ack_idx,
    input  logic [W-1:0]  hw_post,
    input  logic [W-1:0]  hw_clear,
    output logic [W-1:0]  pending,
    output logic [W-1:0]  enable,
    output logic          irq
);

    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic         irq;
    } core_st_t;

    core_st_t     st_d, st_q;
    logic [W-1:0] ack_vec;

    always_comb begin
        ack_vec = '0;
        if (ack_wr && int'(ack_idx) < W) ack_vec = W'(1) << ack_idx;
        st_d = st_q;
        if (mask_wr) st_d.en = ~mask_wdata;
        st_d.pend = (st_q.pend & ~ack_vec & ~hw_clear) | hw_post;
        st_d.irq  = |(st_d.pend & st_d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.pend;
    assign enable  = st_q.en;
    assign irq     = st_q.irq;

    a_r5_post_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_post) |=> ((pending & $past(hw_post)) == $past(hw_post)));

    a_r5_clear_removes: assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_clear & ~hw_post)) |=> ((pending & $past(hw_clear & ~hw_post)) == '0));

    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_vec & ~hw_post)) |=> ((pending & $past(ack_vec & ~hw_post)) == '0));

    a_r2_mask_stored: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr |=> (enable == ~$past(mask_wdata)));

endmodule

// File: rtl/legacy_io_regs.sv
module legacy_io_regs
    import legacy_io_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8,
    parameter int IW = 4,
    parameter int RW = 64,
    parameter logic [DW-1:0] SPKR_VAL = 8'h20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_req,
    input  logic          bus_wr,
    input  logic          bus_wide,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic          rsp_valid,
    output logic [RW-1:0] rsp_rdata,
    output logic          rsp_err,
    input  logic [DW-1:0] hw_post,
    input  logic [DW-1:0] hw_clear,
    output logic          irq,
    output logic [DW-1:0] rtc_idx,
    output logic [DW-1:0] rtc_wdata,
    output logic          rtc_wr,
    output logic          rtc_rd,
    input  logic [DW-1:0] rtc_rdata,
    input  logic          timer2_out,
    output logic [DW-1:0] dma_mode0,
    output logic [DW-1:0] dma_mode1
);

    typedef struct packed {
        logic [DW-1:0] idx;
        logic [DW-1:0] mask2;
        logic [DW-1:0] mode0;
        logic [DW-1:0] mode1;
        logic          valid;
        logic          err;
        logic [RW-1:0] rdata;
    } top_st_t;

    top_st_t       st_d, st_q;
    io_sel_e       sel;
    logic          bad;
    logic          wr_go, rd_go, mask_wr, ack_wr;
    logic [DW-1:0] pending, enable;

    legacy_io_decode #(.AW(AW)) u_decode (
        .wr     (bus_wr),
        .wide   (bus_wide),
        .offset (bus_addr),
        .sel    (sel),
        .bad    (bad)
    );

    assign wr_go   = bus_req && bus_wr && !bad;
    assign rd_go   = bus_req && !bus_wr && !bad;
    assign mask_wr = wr_go && (sel == SEL_P1_MASK);
    assign ack_wr  = wr_go && (sel == SEL_P1_STAT);

    legacy_irq_core #(.W(DW), .IW(IW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (mask_wr),
        .mask_wdata (bus_wdata),
        .ack_wr     (ack_wr),
        .ack_idx    (bus_wdata[IW-1:0]),
        .hw_post    (hw_post),
        .hw_clear   (hw_clear),
        .pending    (pending),
        .enable     (enable),
        .irq        (irq)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = bus_req;
        st_d.err   = bus_req && bad;
        st_d.rdata = '0;
        if (wr_go) begin
            case (sel)
                SEL_P2_MASK:   st_d.mask2 = ~bus_wdata;
                SEL_RTC_IDX:   st_d.idx   = bus_wdata;
                SEL_DMA_MODE0: st_d.mode0 = bus_wdata;
                SEL_DMA_MODE1: st_d.mode1 = bus_wdata;
                default: ;
            endcase
        end
        if (rd_go) begin
            case (sel)
                SEL_P1_MASK:  st_d.rdata[DW-1:0] = ~enable;
                SEL_P2_MASK:  st_d.rdata[DW-1:0] = ~st_q.mask2;
                SEL_P1_STAT:  st_d.rdata[DW-1:0] = pending;
                SEL_RTC_DATA: st_d.rdata[DW-1:0] = rtc_rdata;
                SEL_PORTB:    st_d.rdata[DW-1:0] = timer2_out ? SPKR_VAL : '0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.valid;
    assign rsp_err   = st_q.err;
    assign rsp_rdata = st_q.rdata;
    assign rtc_idx   = st_q.idx;
    assign rtc_wdata = bus_wdata;
    assign rtc_wr    = wr_go && (sel == SEL_RTC_DATA);
    assign rtc_rd    = rd_go && (sel == SEL_RTC_DATA);
    assign dma_mode0 = st_q.mode0;
    assign dma_mode1 = st_q.mode1;

    a_r11_bad_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bad) |=> (rsp_err && rsp_rdata == '0 && $stable(rtc_idx)
                              && $stable(dma_mode0) && $stable(dma_mode1)));

    a_r12_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> rsp_valid);

    a_r12_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !rsp_valid && !rsp_err);

endmodule

// File: tb/test_legacy_io_regs.sv
`timescale 1ns/1ps
module test_legacy_io_regs;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 0, bus_wr = 0, bus_wide = 0;
    logic [7:0]  bus_addr = 0, bus_wdata = 0;
    logic        rsp_valid, rsp_err, irq, rtc_wr, rtc_rd;
    logic [63:0] rsp_rdata;
    logic [7:0]  hw_post = 0, hw_clear = 0, rtc_rdata = 0;
    logic [7:0]  rtc_idx, rtc_wdata, dma_mode0, dma_mode1;
    logic        timer2_out = 0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic [7:0] m_pend = 0, m_en = 0, m_mask2 = 0, m_idx = 0, m_mode0 = 0, m_mode1 = 0;

    always #4 clk = ~clk;

    legacy_io_regs i_legacy_io_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_wide(bus_wide), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .hw_post(hw_post), .hw_clear(hw_clear), .irq(irq),
        .rtc_idx(rtc_idx), .rtc_wdata(rtc_wdata), .rtc_wr(rtc_wr), .rtc_rd(rtc_rd),
        .rtc_rdata(rtc_rdata), .timer2_out(timer2_out),
        .dma_mode0(dma_mode0), .dma_mode1(dma_mode1)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input bit req, input bit wr, input bit wide, input logic [7:0] a,
                        input logic [7:0] d, input logic [7:0] post, input logic [7:0] clr,
                        input string tag);
        bit ok;
        logic [7:0] rv, ackv;
        @(negedge clk);
        bus_req = req; bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = d;
        hw_post = post; hw_clear = clr;
        #1;
        check("R8 rtc_wr", rtc_wr, req && wr && !wide && a == 8'h71);
        check("R8 rtc_rd", rtc_rd, req && !wr && !wide && a == 8'h71);
        if (rtc_wr) check("R8 rtc_wdata", rtc_wdata, d);
        ok = 0; rv = 0; ackv = 0;
        if (req) begin
            if (wide) begin
                ok = !wr && a == 8'h20;
                rv = m_pend;
            end else if (wr) begin
                ok = 1;
                case (a)
                    8'h21: m_en = ~d;
                    8'hA1: m_mask2 = d;
                    8'h20: if (d[3:0] < 8) ackv = 8'(1) << d[3:0];
                    8'h70: m_idx = d;
                    8'h0B: m_mode0 = d;
                    8'hD6: m_mode1 = d;
                    8'h71, 8'h61, 8'hA0, 8'h08, 8'h0A, 8'h0D, 8'h0F,
                    8'hD0, 8'hD4, 8'hDA, 8'hDE, 8'h64: ;
                    default: ok = 0;
                endcase
            end else begin
                ok = 1;
                case (a)
                    8'h21: rv = ~m_en;
                    8'hA1: rv = m_mask2;
                    8'h20: rv = m_pend;
                    8'hA0: rv = 0;
                    8'h71: rv = rtc_rdata;
                    8'h61: rv = timer2_out ? 8'h20 : 8'h00;
                    default: ok = 0;
                endcase
            end
        end
        m_pend = (m_pend & ~ackv & ~clr) | post;
        @(posedge clk);
        #2;
        check("R12 rsp_valid", rsp_valid, req);
        check("R11 rsp_err", rsp_err, req && !ok);
        if (req) check(tag, rsp_rdata, ok ? {56'b0, rv} : 64'b0);
        check("R3 irq", irq, |(m_pend & m_en));
        check("R10 dma_mode0", dma_mode0, m_mode0);
        check("R10 dma_mode1", dma_mode1, m_mode1);
        check("R8 rtc_idx", rtc_idx, m_idx);
        bus_req = 0; hw_post = 0; hw_clear = 0;
    endtask

    task automatic wr8(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(1, 1, 0, a, d, 0, 0, tag);
    endtask
    task automatic rd8(input logic [7:0] a, input string tag);
        step(1, 0, 0, a, 0, 0, 0, tag);
    endtask
    task automatic hw(input logic [7:0] p, input logic [7:0] c, input string tag);
        step(0, 0, 0, 0, 0, p, c, tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #20 rst_n = 1'b1;
        @(posedge clk); #2;
        check("R1 irq", irq, 0);
        check("R1 rsp_valid", rsp_valid, 0);
        check("R1 rsp_err", rsp_err, 0);
        check("R1 rtc_idx", rtc_idx, 0);
        check("R1 dma_mode0", dma_mode0, 0);
        check("R1 dma_mode1", dma_mode1, 0);
        rd8(8'h21, "R1 mask reads FF");
        // R2 complement storage and readback
        wr8(8'h21, 8'hFE, "R2");
        rd8(8'h21, "R2 readback");
        // R3 / R5 post raises, mask toggles the line
        hw(8'h01, 8'h00, "R5 post");
        wr8(8'h21, 8'hFF, "R3 mask drop");
        wr8(8'h21, 8'hFE, "R3 unmask raise");
        // R6 status reads
        rd8(8'h20, "R6 byte status");
        step(1, 0, 1, 8'h20, 0, 0, 0, "R6 wide status");
        rd8(8'hA0, "R6 second status zero");
        // R4 acknowledge by index
        wr8(8'h20, 8'h09, "R4 index 9 ignored");
        wr8(8'h20, 8'h0F, "R4 index 15 ignored");
        rd8(8'h20, "R4 pending kept");
        wr8(8'h20, 8'h00, "R4 index 0 clears");
        // R5 priority
        wr8(8'h21, 8'h00, "R2 enable all");
        hw(8'h0F, 8'h00, "R5 post many");
        hw(8'h02, 8'h06, "R5 post beats clear");
        rd8(8'h20, "R5 pending 0B");
        step(1, 1, 0, 8'h20, 8'h03, 8'h08, 8'h00, "R5 post beats ack");
        wr8(8'h20, 8'h03, "R4 ack bit3");
        hw(8'h00, 8'h0B, "R5 clear all");
        // R7 second mask has no interrupt effect
        wr8(8'hA1, 8'h00, "R7 write");
        rd8(8'hA1, "R7 readback");
        wr8(8'hA1, 8'h5C, "R7 write 2");
        rd8(8'hA1, "R7 readback 2");
        // R8 clock port pair
        wr8(8'h70, 8'h0D, "R8 idx");
        wr8(8'h71, 8'h5A, "R8 data write");
        rtc_rdata = 8'h3C;
        rd8(8'h71, "R8 data read");
        // R9 control port
        timer2_out = 1'b1;
        rd8(8'h61, "R9 high");
        timer2_out = 1'b0;
        rd8(8'h61, "R9 low");
        wr8(8'h61, 8'hFF, "R9 write accepted");
        // R10 DMA modes and sinks
        wr8(8'h0B, 8'h46, "R10 mode0");
        wr8(8'hD6, 8'h4A, "R10 mode1");
        wr8(8'h08, 8'h11, "R10 sink");
        wr8(8'hDE, 8'h22, "R10 sink");
        wr8(8'h64, 8'h33, "R10 sink");
        wr8(8'hA0, 8'h01, "R10 second ack");
        // R11 rejected accesses
        rd8(8'h33, "R11 undecoded read");
        wr8(8'h55, 8'h77, "R11 undecoded write");
        rd8(8'h0B, "R11 write-only read");
        rd8(8'h70, "R11 write-only read idx");
        step(1, 0, 1, 8'h21, 0, 0, 0, "R11 wide mask read");
        step(1, 1, 1, 8'h0B, 8'h99, 0, 0, "R11 wide write");
        rd8(8'h21, "R11 enable kept");
        hw(8'h00, 8'h00, "R12 idle");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule